// File: doc/BRIEF.md
# Packed Element Left Bit Shifter

This block shifts every element of a packed vector left by one common bit count. Vacated low-order bits fill with zeros. Elements may be 16, 32 or 64 bits wide. The count comes either from an 8-bit immediate or from a 128-bit count operand. A count that does not fit inside the element width does not wrap. It clears every element that the selected width mode produces.

Three width modes set how much of the vector is processed. The legacy 128-bit mode shifts the prior destination value in place and keeps its upper half. The extended 128-bit mode shifts the low half of the source vector and zeroes the upper half. The 256-bit mode shifts all elements of the source vector.

The result is registered, so it appears one cycle after `in_valid`. A two-state controller sequences the output register:
- `S_EMPTY` means no result is held. It moves to `S_HOLD` on `in_valid`.
- `S_HOLD` means a fresh result is presented. It stays in `S_HOLD` while `in_valid` repeats, and returns to `S_EMPTY` when `in_valid` is low.

`out_valid` is high only in `S_HOLD`. A synchronous reset forces `S_EMPTY` and clears the result.

Top module: `pk_shl_top`

## Requirements
- R1: Each element is shifted left on its own by the count, and its low bits fill with zeros. Element size is set by `elem_sel`: 00 selects 16-bit, 01 selects 32-bit and 10 selects 64-bit elements.
- R2: A count larger than the element width minus one makes every shifted element zero. A count equal to the width minus one still shifts.
- R3: With `cnt_sel`=0 the count is `imm_cnt`, zero-extended. With `cnt_sel`=1 the count is `reg_cnt[63:0]`; bits 127:64 are ignored, and all 64 bits take part in the range test.
- R4: Mode 00 (legacy 128-bit) shifts `prev_dst[127:0]` into `result[127:0]` and copies `prev_dst[255:128]` unchanged. `src_vec` is ignored in this mode.
- R5: Mode 01 (extended 128-bit) shifts `src_vec[127:0]` into `result[127:0]` and clears `result[255:128]`.
- R6: Mode 10 (256-bit) shifts every element of `src_vec` across all 256 bits. An out-of-range count clears all 256 bits.
- R7: `elem_sel`=11 makes the shifted portion of the result zero, while the upper half still follows the mode.
- R8: Mode 11 makes the whole result zero.
- R9: `result` and `out_valid` update on the clock edge that samples `in_valid`=1. A cycle with `in_valid`=0 drops `out_valid` and holds `result`.
- R10: A synchronous reset clears `out_valid` and `result`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| in_valid | input | 1 | Operation request |
| src_vec | input | 256 | Source vector |
| prev_dst | input | 256 | Prior destination value |
| imm_cnt | input | 8 | Immediate count |
| reg_cnt | input | 128 | Count operand |
| cnt_sel | input | 1 | 0 selects the immediate, 1 selects the count operand |
| elem_sel | input | 2 | Element size code |
| mode_sel | input | 2 | Width mode code |
| out_valid | output | 1 | Result is fresh |
| result | output | 256 | Registered shifted vector |

## Verification
The assertions assume that `rst` is high at the first clock edge. They also assume that the operand, count and select inputs are known whenever `in_valid` is high, because the mode and range checks compare the registered result with `$past` of those inputs.

The bench drives every input only at the falling clock edge and starts with reset asserted. It sweeps all four mode codes and all four element codes with both count sources. The counts include each width minus one, each width itself, and values with bits set above bit 7. After every request it inserts one idle cycle with altered operands, so the hold behaviour is observed.

// File: rtl/pk_shl_pkg.sv
package pk_shl_pkg;

    typedef enum logic [1:0] {
        MODE_LEGACY128 = 2'b00,
        MODE_EXT128    = 2'b01,
        MODE_WIDE256   = 2'b10,
        MODE_BLANK     = 2'b11
    } shl_mode_e;

    typedef enum logic [1:0] {
        ELEM_16   = 2'b00,
        ELEM_32   = 2'b01,
        ELEM_64   = 2'b10,
        ELEM_NONE = 2'b11
    } shl_elem_e;

    typedef enum logic {
        S_EMPTY = 1'b0,
        S_HOLD  = 1'b1
    } shl_state_e;

    localparam int unsigned NUM_SIZES = 3;
    localparam int unsigned MIN_ELEM_W = 16;

endpackage

// File: rtl/pk_shl_count.sv
module pk_shl_count
    import pk_shl_pkg::*;
#(
    parameter int unsigned IMM_W    = 8,
    parameter int unsigned CNT_OP_W = 128,
    parameter int unsigned CNT_W    = 64,
    parameter int unsigned AMT_W    = 6
) (
    input  logic                cnt_sel,
    input  logic [IMM_W-1:0]    imm_cnt,
    input  logic [CNT_OP_W-1:0] reg_cnt,
    input  logic [1:0]          elem_sel,
    output logic [AMT_W-1:0]    amt,
    output logic                in_range
);

    logic [CNT_W-1:0] cnt_full;
    logic [CNT_W-1:0] limit;
    logic             unused_cnt_hi;

    // Upper half of the count operand never reaches the comparison.
    assign unused_cnt_hi = ^reg_cnt[CNT_OP_W-1:CNT_W];

    always_comb begin
        if (cnt_sel) begin
            cnt_full = reg_cnt[CNT_W-1:0];
        end else begin
            cnt_full = '0;
            cnt_full[IMM_W-1:0] = imm_cnt;
        end
    end

    always_comb begin
        unique case (shl_elem_e'(elem_sel))
            ELEM_16: limit = CNT_W'(MIN_ELEM_W);
            ELEM_32: limit = CNT_W'(MIN_ELEM_W * 2);
            ELEM_64: limit = CNT_W'(MIN_ELEM_W * 4);
            default: limit = '0;
        endcase
    end

    // Full-width compare: any bit above the element index range disqualifies.
    assign in_range = (cnt_full < limit);
    assign amt      = cnt_full[AMT_W-1:0];

endmodule

// File: rtl/pk_shl_array.sv
module pk_shl_array #(
    parameter int unsigned VEC_W = 256,
    parameter int unsigned EW    = 16,
    parameter int unsigned AMT_W = 6
) (
    input  logic [VEC_W-1:0] vec_in,
    input  logic [AMT_W-1:0] amt,
    output logic [VEC_W-1:0] vec_out
);

    localparam int unsigned N_ELEM = VEC_W / EW;

    for (genvar e = 0; e < N_ELEM; e++) begin : g_elem
        assign vec_out[e*EW +: EW] = vec_in[e*EW +: EW] << amt;
    end

endmodule

// File: rtl/pk_shl_top.sv
module pk_shl_top
    import pk_shl_pkg::*;
#(
    parameter int unsigned VEC_W    = 256,
    parameter int unsigned IMM_W    = 8,
    parameter int unsigned CNT_OP_W = 128,
    parameter int unsigned CNT_W    = 64
) (
    input  logic                clk,
    input  logic                rst,
    input  logic                in_valid,
    input  logic [VEC_W-1:0]    src_vec,
    input  logic [VEC_W-1:0]    prev_dst,
    input  logic [IMM_W-1:0]    imm_cnt,
    input  logic [CNT_OP_W-1:0] reg_cnt,
    input  logic                cnt_sel,
    input  logic [1:0]          elem_sel,
    input  logic [1:0]          mode_sel,
    output logic                out_valid,
    output logic [VEC_W-1:0]    result
);

    localparam int unsigned HALF_W   = VEC_W / 2;
    localparam int unsigned MAX_EW   = MIN_ELEM_W << (NUM_SIZES - 1);
    localparam int unsigned AMT_W    = $clog2(MAX_EW);

    shl_state_e          state_q, state_d;
    logic [AMT_W-1:0]    amt;
    logic                in_range;
    logic [VEC_W-1:0]    operand;
    logic [VEC_W-1:0]    cand [NUM_SIZES];
    logic [VEC_W-1:0]    shifted;
    logic [VEC_W-1:0]    next_res;

    pk_shl_count #(
        .IMM_W    (IMM_W),
        .CNT_OP_W (CNT_OP_W),
        .CNT_W    (CNT_W),
        .AMT_W    (AMT_W)
    ) u_count (
        .cnt_sel  (cnt_sel),
        .imm_cnt  (imm_cnt),
        .reg_cnt  (reg_cnt),
        .elem_sel (elem_sel),
        .amt      (amt),
        .in_range (in_range)
    );

    // Legacy mode works on the prior destination in place.
    assign operand = (shl_mode_e'(mode_sel) == MODE_LEGACY128) ? prev_dst : src_vec;

    for (genvar k = 0; k < NUM_SIZES; k++) begin : g_size
        pk_shl_array #(
            .VEC_W (VEC_W),
            .EW    (MIN_ELEM_W << k),
            .AMT_W (AMT_W)
        ) u_array (
            .vec_in  (operand),
            .amt     (amt),
            .vec_out (cand[k])
        );
    end

    always_comb begin
        shifted = '0;
        if (in_range) begin
            unique case (shl_elem_e'(elem_sel))
                ELEM_16: shifted = cand[0];
                ELEM_32: shifted = cand[1];
                ELEM_64: shifted = cand[2];
                default: shifted = '0;
            endcase
        end
    end

    always_comb begin
        unique case (shl_mode_e'(mode_sel))
            MODE_LEGACY128: next_res = {prev_dst[VEC_W-1:HALF_W], shifted[HALF_W-1:0]};
            MODE_EXT128:    next_res = {{HALF_W{1'b0}}, shifted[HALF_W-1:0]};
            MODE_WIDE256:   next_res = shifted;
            default:        next_res = '0;
        endcase
    end

    always_comb begin
        unique case (state_q)
            S_EMPTY: state_d = in_valid ? S_HOLD : S_EMPTY;
            S_HOLD:  state_d = in_valid ? S_HOLD : S_EMPTY;
            default: state_d = S_EMPTY;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= S_EMPTY;
        end else begin
            state_q <= state_d;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            result <= '0;
        end else if (in_valid) begin
            result <= next_res;
        end
    end

    assign out_valid = (state_q == S_HOLD);

    // Assertions
    p_reset_clear_r10: assert property (@(posedge clk)
        rst |=> (!out_valid && result == '0));

    p_valid_latency_r9: assert property (@(posedge clk) disable iff (rst)
        in_valid |=> out_valid);

    p_idle_hold_r9: assert property (@(posedge clk) disable iff (rst)
        !in_valid |=> (!out_valid && $stable(result)));

    p_legacy_upper_r4: assert property (@(posedge clk) disable iff (rst)
        (in_valid && mode_sel == MODE_LEGACY128)
        |=> result[VEC_W-1:HALF_W] == $past(prev_dst[VEC_W-1:HALF_W]));

    p_ext_upper_zero_r5: assert property (@(posedge clk) disable iff (rst)
        (in_valid && mode_sel == MODE_EXT128) |=> result[VEC_W-1:HALF_W] == '0);

    p_wide_over_zero_r2: assert property (@(posedge clk) disable iff (rst)
        (in_valid && !in_range && mode_sel == MODE_WIDE256) |=> result == '0);

    p_blank_mode_r8: assert property (@(posedge clk) disable iff (rst)
        (in_valid && mode_sel == MODE_BLANK) |=> result == '0);

endmodule

// File: tb/pk_shl_top_bench.sv
module pk_shl_top_bench;

    localparam int CLK_PERIOD = 10;
    localparam int VW = 256;

    logic           clk = 1'b0;
    logic           rst = 1'b1;
    logic           in_valid = 1'b0;
    logic [VW-1:0]  src_vec = '0;
    logic [VW-1:0]  prev_dst = '0;
    logic [7:0]     imm_cnt = '0;
    logic [127:0]   reg_cnt = '0;
    logic           cnt_sel = 1'b0;
    logic [1:0]     elem_sel = '0;
    logic [1:0]     mode_sel = '0;
    logic           out_valid;
    logic [VW-1:0]  result;

    int n_checks = 0;
    int n_fail = 0;
    bit done = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    pk_shl_top u_pk_shl_top (
        .clk(clk), .rst(rst), .in_valid(in_valid), .src_vec(src_vec),
        .prev_dst(prev_dst), .imm_cnt(imm_cnt), .reg_cnt(reg_cnt),
        .cnt_sel(cnt_sel), .elem_sel(elem_sel), .mode_sel(mode_sel),
        .out_valid(out_valid), .result(result)
    );

    task automatic check_vec(input string req, input logic [VW-1:0] act, input logic [VW-1:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic check_bit(input string req, input logic act, input logic exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %b expected %b", req, act, exp);
        end
    endtask

    // Independent model: bit-by-bit placement from the requirement text.
    function automatic logic [VW-1:0] model(input int md, input int es, input bit cs,
        input logic [7:0] im, input logic [127:0] rc, input logic [VW-1:0] s, input logic [VW-1:0] p);
        logic [63:0] c;
        logic [VW-1:0] op;
        logic [VW-1:0] sh;
        int w;
        int span;
        int ci;
        c = cs ? rc[63:0] : {56'd0, im};
        w = (es == 0) ? 16 : (es == 1) ? 32 : (es == 2) ? 64 : 0;
        op = (md == 0) ? p : s;
        span = (md == 2) ? VW : VW / 2;
        sh = '0;
        if (w != 0 && c < 64'(w)) begin
            ci = int'(c[6:0]);
            for (int i = 0; i < span; i++) begin
                if ((i % w) >= ci) sh[i] = op[i - ci];
            end
        end
        case (md)
            0: model = {p[VW-1:VW/2], sh[VW/2-1:0]};
            1: model = {{(VW/2){1'b0}}, sh[VW/2-1:0]};
            2: model = sh;
            default: model = '0;
        endcase
    endfunction

    function automatic string tag(input int md, input int es, input bit cs, input bit over);
        string t;
        t = (md == 0) ? "R4" : (md == 1) ? "R5" : (md == 2) ? "R6" : "R8";
        if (es == 3) t = {t, "/R7"};
        else if (over) t = {t, "/R2"};
        else t = {t, "/R1"};
        if (cs) t = {t, "/R3"};
        return t;
    endfunction

    initial begin
        #(CLK_PERIOD * 200000);
        if (!done) begin
            n_fail++;
            n_checks++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
            $finish;
        end
    end

    initial begin
        logic [63:0] imm_list [10];
        logic [63:0] reg_list [10];
        logic [VW-1:0] exp_v;
        logic [63:0] cv;
        bit over;
        int w;

        imm_list = '{64'd0, 64'd1, 64'd7, 64'd15, 64'd16, 64'd31, 64'd32, 64'd63, 64'd64, 64'd200};
        reg_list = '{64'd3, 64'd15, 64'd16, 64'd31, 64'd32, 64'd63, 64'd64,
                     64'h105, 64'h0000_0100_0000_0002, 64'h8000_0000_0000_0001};

        // R10: reset state
        repeat (3) @(posedge clk);
        @(negedge clk);
        check_bit("R10 valid", out_valid, 1'b0);
        check_vec("R10 result", result, '0);
        rst = 1'b0;

        for (int pat = 0; pat < 2; pat++) begin
            for (int b = 0; b < VW/8; b++) begin
                src_vec[b*8 +: 8]  = 8'((b * 37 + pat * 91 + 1) ^ (pat ? 8'hA5 : 8'h3C));
                prev_dst[b*8 +: 8] = 8'(~(b * 13 + 5 + pat * 29));
            end
            for (int md = 0; md < 4; md++) begin
                for (int es = 0; es < 4; es++) begin
                    for (int cs = 0; cs < 2; cs++) begin
                        for (int ci = 0; ci < 10; ci++) begin
                            @(negedge clk);
                            in_valid = 1'b1;
                            mode_sel = 2'(md);
                            elem_sel = 2'(es);
                            cnt_sel  = cs[0];
                            imm_cnt  = imm_list[ci][7:0];
                            reg_cnt  = {64'hF0F0_1234_5678_9ABC, reg_list[ci]};
                            exp_v = model(md, es, cs[0], imm_cnt, reg_cnt, src_vec, prev_dst);
                            cv = cs[0] ? reg_list[ci] : imm_list[ci];
                            w = (es == 0) ? 16 : (es == 1) ? 32 : 64;
                            over = (cv >= 64'(w));
                            @(negedge clk);
                            check_vec(tag(md, es, cs[0], over), result, exp_v);
                            check_bit("R9 valid after request", out_valid, 1'b1);
                            // idle cycle: operands change, output must hold
                            in_valid = 1'b0;
                            src_vec  = ~src_vec;
                            prev_dst = ~prev_dst;
                            @(negedge clk);
                            check_vec("R9 hold", result, exp_v);
                            check_bit("R9 valid idle", out_valid, 1'b0);
                            src_vec  = ~src_vec;
                            prev_dst = ~prev_dst;
                        end
                    end
                end
            end
        end

        // R10: reset mid-stream clears a held result
        @(negedge clk);
        rst = 1'b1;
        @(negedge clk);
        check_vec("R10 result after reset", result, '0);
        check_bit("R10 valid after reset", out_valid, 1'b0);
        rst = 1'b0;

        done = 1'b1;
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end

endmodule